// File: doc/BRIEF.md
# Register-Programmed Display Timing Generator

This block generates raster timing for a display pipe. Software programs the frame geometry through a single-cycle register write port, using packed 32-bit words. The block counts pixels along a line and lines down a frame. From those counts it drives horizontal sync, vertical sync, a display-enable strobe and the current pixel and line position. Horizontal geometry is given in eight-pixel character cells and stored minus one. Vertical geometry is given in plain lines.

The same write port also carries a general control word and a line-pitch word. The control word holds a pixel-depth code and a lock bit. The pitch word holds the line pitch in character cells. The block decodes both and drives them as outputs for a downstream fetch engine.

Timing writes land in a pending copy. That copy becomes the working geometry only when the raster wraps back to pixel 0 of line 0, so a reprogram mid-frame never tears a frame. While the lock bit is set, writes to the four timing words are dropped.

Top module: `crtc_timing_gen`

## Requirements
- R1: While reset is asserted, the pixel and line position are 0 and the geometry equals the reset-value parameters. The depth and pitch outputs are 0.
- R2: The pixel count runs from 0 to (T+1)*8-1 and then returns to 0. T is bits [H_CHAR_W-1:0] of the horizontal geometry word (word select 0).
- R3: The line count advances once per line wrap and runs from 0 to V. V is bits [V_LINE_W-1:0] of the vertical geometry word (word select 2). Once the last pixel of line V has been counted, the raster returns to pixel 0 of line 0.
- R4: Display enable is high exactly when pixel < (D+1)*8 and line < E+1. D is the horizontal field at bit 16 of word 0. E is the vertical field at bit 16 of word 2.
- R5: The horizontal sync pulse is active for pixels from (S+1)*8 up to, but not including, (S+1)*8 + W*8. S is the low field of the horizontal sync word (word select 1). W is bits [20:16] of that word.
- R6: The vertical sync pulse is active for lines from S+1 up to, but not including, S+1+W. S is the low field of the vertical sync word (word select 3). W is bits [20:16] of that word.
- R7: Bit 21 of each sync word inverts that sync output, which makes the pulse active low. When bit 21 is clear, the pulse is active high.
- R8: While bit 22 of the control word (word select 4) is set, writes to word selects 0 to 3 have no effect. The control word itself stays writable, so software can clear the bit to unlock.
- R9: A new geometry written mid-frame has no effect on the current frame. It first applies at the next return to pixel 0 of line 0.
- R10: Control bits [10:8] are presented as the depth code, and the bits-per-pixel output decodes them as 1→1, 2→8, 3→15, 4→16, 5→24, 6→32. Codes 0 and 7 give 0. Both outputs follow a control write at the next clock.
- R11: The pitch output equals bits [31:22] of the pitch word (word select 5) times 8, and follows a write at the next clock. All other bits of the word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register word select |
| wr_data | input | 32 | Register write data |
| pix_x | output | H_CHAR_W+3 | Current pixel within the line |
| pix_y | output | V_LINE_W | Current line within the frame |
| de | output | 1 | Display enable |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| depth_code | output | 3 | Raw pixel-depth code |
| bpp | output | 6 | Decoded bits per pixel |
| pitch_px | output | PITCH_W+3 | Line pitch in pixels |

## Verification
The bench overrides the reset-value parameters with a tiny geometry: 32-pixel lines and 5-line frames. A whole frame from reset can therefore be compared cycle by cycle against counts the bench derives from the requirement formulas. The other width parameters keep their defaults, so a real 640-pixel line with an 800-pixel total fits in the 12-bit pixel counter. The bench uses this line with both sync polarities, over a shortened 10-line frame so a full frame stays short. The small geometry also makes the frame-boundary and lock scenarios quick, because each needs several frame wraps.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

   typedef enum logic [2:0] {
      SEL_HGEO  = 3'd0,
      SEL_HSYNC = 3'd1,
      SEL_VGEO  = 3'd2,
      SEL_VSYNC = 3'd3,
      SEL_CTRL  = 3'd4,
      SEL_PITCH = 3'd5
   } word_sel_e;

   localparam int WORD_W      = 32;
   localparam int HI_LSB      = 16;
   localparam int SYNC_W_BITS = 5;
   localparam int POL_BIT     = 21;
   localparam int LOCK_BIT    = 22;
   localparam int DEPTH_LSB   = 8;
   localparam int PITCH_LSB   = 22;

   typedef struct packed {
      logic [WORD_W-1:0] hgeo;
      logic [WORD_W-1:0] hsyn;
      logic [WORD_W-1:0] vgeo;
      logic [WORD_W-1:0] vsyn;
   } geom_t;

   function automatic logic [5:0] depth_to_bpp(input logic [2:0] code);
      logic [5:0] r;
      case (code)
         3'd1:    r = 6'd1;
         3'd2:    r = 6'd8;
         3'd3:    r = 6'd15;
         3'd4:    r = 6'd16;
         3'd5:    r = 6'd24;
         3'd6:    r = 6'd32;
         default: r = 6'd0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
   import crtc_pkg::*;
#(
   parameter logic [31:0] RST_HGEO  = 32'h004F_0063,
   parameter logic [31:0] RST_HSYNC = 32'h002C_0051,
   parameter logic [31:0] RST_VGEO  = 32'h01DF_020C,
   parameter logic [31:0] RST_VSYNC = 32'h0022_01E9,
   parameter logic [31:0] RST_CTRL  = 32'h0000_0000,
   parameter bit          STAGE_AT_FRAME = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              frame_wrap,
   output geom_t             geom,
   output logic [WORD_W-1:0] ctrl,
   output logic [WORD_W-1:0] pitch
);

   localparam geom_t RST_GEOM = '{hgeo: RST_HGEO, hsyn: RST_HSYNC,
                                  vgeo: RST_VGEO, vsyn: RST_VSYNC};

   geom_t pend;
   logic  locked;

   assign locked = ctrl[LOCK_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend  <= RST_GEOM;
         ctrl  <= RST_CTRL;
         pitch <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_HGEO:  if (!locked) pend.hgeo <= wr_data;
            SEL_HSYNC: if (!locked) pend.hsyn <= wr_data;
            SEL_VGEO:  if (!locked) pend.vgeo <= wr_data;
            SEL_VSYNC: if (!locked) pend.vsyn <= wr_data;
            SEL_CTRL:  ctrl  <= wr_data;
            SEL_PITCH: pitch <= wr_data;
            default: ;
         endcase
      end
   end

   // R8
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && locked && (wr_sel <= 3'd3)) |=> $stable(pend))
      else $error("timing word changed while locked");

   generate
      if (STAGE_AT_FRAME) begin : g_staged
         geom_t work;
         always_ff @(posedge clk) begin
            if (!rst_n)          work <= RST_GEOM;
            else if (frame_wrap) work <= pend;
         end
         assign geom = work;

         // R9
         geom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_wrap |=> $stable(geom))
            else $error("working geometry changed away from frame wrap");
      end else begin : g_direct
         assign geom = pend;
      end
   endgenerate

endmodule

// File: rtl/crtc_axis.sv
module crtc_axis #(
   parameter int CNT_W = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           step,
   input  logic [CNT_W-1:0] last_val,
   input  logic [CNT_W:0]   disp_end,
   input  logic [CNT_W:0]   sync_beg,
   input  logic [CNT_W:0]   sync_end,
   output logic [CNT_W-1:0] cnt,
   output logic           at_last,
   output logic           in_disp,
   output logic           in_sync
);

   logic [CNT_W:0] cnt_x;

   assign cnt_x   = {1'b0, cnt};
   assign at_last = (cnt >= last_val);
   assign in_disp = (cnt_x < disp_end);
   assign in_sync = (cnt_x >= sync_beg) && (cnt_x < sync_end);

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (step)    cnt <= at_last ? '0 : cnt + 1'b1;
   end

   // R2
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && at_last) |=> (cnt == '0))
      else $error("counter did not return to zero at its last value");

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt))
      else $error("counter moved without a step");

endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
   import crtc_pkg::*;
#(
   parameter int          H_CHAR_W  = 9,
   parameter int          V_LINE_W  = 11,
   parameter int          CHAR_PX   = 8,
   parameter int          PITCH_W   = 10,
   parameter bit          STAGE_AT_FRAME = 1'b1,
   parameter logic [31:0] RST_HGEO  = 32'h004F_0063,
   parameter logic [31:0] RST_HSYNC = 32'h002C_0051,
   parameter logic [31:0] RST_VGEO  = 32'h01DF_020C,
   parameter logic [31:0] RST_VSYNC = 32'h0022_01E9,
   parameter logic [31:0] RST_CTRL  = 32'h0000_0000,
   localparam int         CHAR_SH   = $clog2(CHAR_PX),
   localparam int         H_PIX_W   = H_CHAR_W + CHAR_SH,
   localparam int         PITCH_PX_W = PITCH_W + CHAR_SH
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [2:0]            wr_sel,
   input  logic [31:0]           wr_data,
   output logic [H_PIX_W-1:0]    pix_x,
   output logic [V_LINE_W-1:0]   pix_y,
   output logic                  de,
   output logic                  hsync,
   output logic                  vsync,
   output logic [2:0]            depth_code,
   output logic [5:0]            bpp,
   output logic [PITCH_PX_W-1:0] pitch_px
);

   generate
      if (CHAR_PX != (1 << CHAR_SH)) begin : g_bad_char
         $error("CHAR_PX must be a power of two");
      end
      if (H_CHAR_W > HI_LSB || V_LINE_W > HI_LSB) begin : g_bad_field
         $error("geometry fields must fit in sixteen bits");
      end
      if (PITCH_W > WORD_W - PITCH_LSB) begin : g_bad_pitch
         $error("pitch field exceeds the word");
      end
      if (V_LINE_W < SYNC_W_BITS || H_PIX_W < SYNC_W_BITS + CHAR_SH) begin : g_bad_sync
         $error("counter narrower than sync width field");
      end
   endgenerate

   geom_t       geom;
   logic [31:0] ctrl;
   logic [31:0] pitch;
   logic        frame_wrap;

   crtc_regs #(
      .RST_HGEO(RST_HGEO), .RST_HSYNC(RST_HSYNC), .RST_VGEO(RST_VGEO),
      .RST_VSYNC(RST_VSYNC), .RST_CTRL(RST_CTRL), .STAGE_AT_FRAME(STAGE_AT_FRAME)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .frame_wrap(frame_wrap), .geom(geom), .ctrl(ctrl), .pitch(pitch)
   );

   // horizontal fields, character units, stored minus one
   logic [H_CHAR_W-1:0]    h_tot, h_dsp, h_ss;
   logic [SYNC_W_BITS-1:0] h_sw;
   logic [H_PIX_W-1:0]     h_last;
   logic [H_PIX_W:0]       h_dend, h_sbeg, h_send;

   assign h_tot  = geom.hgeo[H_CHAR_W-1:0];
   assign h_dsp  = geom.hgeo[HI_LSB +: H_CHAR_W];
   assign h_ss   = geom.hsyn[H_CHAR_W-1:0];
   assign h_sw   = geom.hsyn[HI_LSB +: SYNC_W_BITS];
   assign h_last = {h_tot, {CHAR_SH{1'b1}}};
   assign h_dend = ({{(CHAR_SH+1){1'b0}}, h_dsp} + {{H_PIX_W{1'b0}}, 1'b1}) << CHAR_SH;
   assign h_sbeg = ({{(CHAR_SH+1){1'b0}}, h_ss} + {{H_PIX_W{1'b0}}, 1'b1}) << CHAR_SH;
   assign h_send = h_sbeg + ({{(H_PIX_W+1-SYNC_W_BITS){1'b0}}, h_sw} << CHAR_SH);

   // vertical fields, line units
   logic [V_LINE_W-1:0]    v_tot, v_dsp, v_ss;
   logic [SYNC_W_BITS-1:0] v_sw;
   logic [V_LINE_W:0]      v_dend, v_sbeg, v_send;

   assign v_tot  = geom.vgeo[V_LINE_W-1:0];
   assign v_dsp  = geom.vgeo[HI_LSB +: V_LINE_W];
   assign v_ss   = geom.vsyn[V_LINE_W-1:0];
   assign v_sw   = geom.vsyn[HI_LSB +: SYNC_W_BITS];
   assign v_dend = {1'b0, v_dsp} + {{V_LINE_W{1'b0}}, 1'b1};
   assign v_sbeg = {1'b0, v_ss}  + {{V_LINE_W{1'b0}}, 1'b1};
   assign v_send = v_sbeg + {{(V_LINE_W+1-SYNC_W_BITS){1'b0}}, v_sw};

   logic h_at_last, h_in_disp, h_in_sync;
   logic v_at_last, v_in_disp, v_in_sync;

   crtc_axis #(.CNT_W(H_PIX_W)) u_hcnt (
      .clk(clk), .rst_n(rst_n), .step(1'b1), .last_val(h_last),
      .disp_end(h_dend), .sync_beg(h_sbeg), .sync_end(h_send),
      .cnt(pix_x), .at_last(h_at_last), .in_disp(h_in_disp), .in_sync(h_in_sync)
   );

   crtc_axis #(.CNT_W(V_LINE_W)) u_vcnt (
      .clk(clk), .rst_n(rst_n), .step(h_at_last), .last_val(v_tot),
      .disp_end(v_dend), .sync_beg(v_sbeg), .sync_end(v_send),
      .cnt(pix_y), .at_last(v_at_last), .in_disp(v_in_disp), .in_sync(v_in_sync)
   );

   assign frame_wrap = h_at_last & v_at_last;
   assign de         = h_in_disp & v_in_disp;
   assign hsync      = h_in_sync ^ geom.hsyn[POL_BIT];
   assign vsync      = v_in_sync ^ geom.vsyn[POL_BIT];

   assign depth_code = ctrl[DEPTH_LSB +: 3];
   assign bpp        = depth_to_bpp(depth_code);
   assign pitch_px   = {pitch[PITCH_LSB +: PITCH_W], {CHAR_SH{1'b0}}};

   // R3
   line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_at_last && !v_at_last) |=> (pix_y == $past(pix_y) + 1'b1))
      else $error("line did not advance at end of line");

   // R4
   de_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> ({1'b0, pix_y} <= {1'b0, v_dsp}))
      else $error("display enable outside active lines");

endmodule

// File: tb/sim_crtc_timing_gen.sv
module sim_crtc_timing_gen;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [11:0] pix_x;
   logic [10:0] pix_y;
   logic        de, hsync, vsync;
   logic [2:0]  depth_code;
   logic [5:0]  bpp;
   logic [12:0] pitch_px;

   int nchecks = 0;
   int nerrs   = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   crtc_timing_gen #(
      .RST_HGEO (32'h0001_0003),
      .RST_HSYNC(32'h0001_0001),
      .RST_VGEO (32'h0002_0004),
      .RST_VSYNC(32'h0001_0002)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pix_x(pix_x), .pix_y(pix_y), .de(de), .hsync(hsync), .vsync(vsync),
      .depth_code(depth_code), .bpp(bpp), .pitch_px(pitch_px)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      nchecks++;
      if (!ok) begin
         nerrs++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_frame_start();
      @(negedge clk);
      while (!(pix_x == 0 && pix_y == 0)) @(negedge clk);
   endtask

   task automatic check_frame(input int htf, input int hdf, input int hsf, input int hwf,
                              input bit hneg, input int vtf, input int vdf, input int vsf,
                              input int vwf, input bit vneg, input string tag);
      int htp = (htf + 1) * 8;
      int hdp = (hdf + 1) * 8;
      int hsb = (hsf + 1) * 8;
      int hse = hsb + hwf * 8;
      int vsb = vsf + 1;
      int vse = vsb + vwf;
      int total = htp * (vtf + 1);
      wait_frame_start();
      for (int n = 0; n <= total; n++) begin
         int ex = n % htp;
         int ey = (n / htp) % (vtf + 1);
         bit ede = (ex < hdp) && (ey < vdf + 1);
         bit ehs = ((ex >= hsb) && (ex < hse)) ^ hneg;
         bit evs = ((ey >= vsb) && (ey < vse)) ^ vneg;
         if (n > 0) @(negedge clk);
         chk(int'(pix_x) == ex, {tag, " R2 pixel"}, int'(pix_x), ex);
         chk(int'(pix_y) == ey, {tag, " R3 line"}, int'(pix_y), ey);
         chk(de == ede, {tag, " R4 de"}, int'(de), int'(ede));
         chk(hsync == ehs, {tag, " R5/R7 hsync"}, int'(hsync), int'(ehs));
         chk(vsync == evs, {tag, " R6/R7 vsync"}, int'(vsync), int'(evs));
      end
   endtask

   task automatic line_len_check(input int len, input string tag);
      wait_frame_start();
      repeat (len - 1) @(negedge clk);
      chk(int'(pix_x) == len - 1 && pix_y == 0, {tag, " last pixel"}, int'(pix_x), len - 1);
      @(negedge clk);
      chk(pix_x == 0 && pix_y == 1, {tag, " wrap to line 1"}, int'(pix_y), 1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(pix_x == 0, "R1 reset pixel", int'(pix_x), 0);
      chk(pix_y == 0, "R1 reset line", int'(pix_y), 0);
      chk(de == 1'b1, "R1 reset de", int'(de), 1);
      chk(hsync == 1'b0 && vsync == 1'b0, "R1 reset syncs", int'({hsync, vsync}), 0);
      chk(bpp == 0 && depth_code == 0, "R1 reset depth", int'(bpp), 0);
      chk(pitch_px == 0, "R1 reset pitch", int'(pitch_px), 0);
   endtask

   task automatic t_default_frame();
      check_frame(3, 1, 1, 1, 1'b0, 4, 2, 2, 1, 1'b0, "R1 reset geometry");
   endtask

   task automatic t_vga_neg();
      wr(3'd0, (32'd79 << 16) | 32'd99);
      wr(3'd1, (32'd12 << 16) | 32'd81 | (32'd1 << 21));
      wr(3'd2, (32'd5 << 16) | 32'd9);
      wr(3'd3, (32'd2 << 16) | 32'd6 | (32'd1 << 21));
      check_frame(99, 79, 81, 12, 1'b1, 9, 5, 6, 2, 1'b1, "R7 640 line active low");
   endtask

   task automatic t_vga_pos();
      wr(3'd1, (32'd12 << 16) | 32'd81);
      wr(3'd3, (32'd2 << 16) | 32'd6);
      check_frame(99, 79, 81, 12, 1'b0, 9, 5, 6, 2, 1'b0, "R7 640 line active high");
   endtask

   task automatic t_frame_boundary();
      int maxx = 0;
      wr(3'd0, 32'h0001_0003);
      wr(3'd1, 32'h0001_0001);
      wr(3'd2, 32'h0002_0004);
      wr(3'd3, 32'h0001_0002);
      wait_frame_start();
      while (pix_y != 1) @(negedge clk);
      wr(3'd0, 32'h0001_0005);
      @(negedge clk);
      while (pix_y != 0) begin
         if (int'(pix_x) > maxx) maxx = int'(pix_x);
         @(negedge clk);
      end
      chk(maxx == 31, "R9 old line length kept until frame end", maxx, 31);
      chk(pix_x == 0, "R9 new frame starts at pixel 0", int'(pix_x), 0);
      repeat (47) @(negedge clk);
      chk(pix_x == 47 && pix_y == 0, "R9 new length in next frame", int'(pix_x), 47);
      @(negedge clk);
      chk(pix_x == 0 && pix_y == 1, "R9 new line wraps", int'(pix_x), 0);
   endtask

   task automatic t_lock();
      wr(3'd4, 32'd1 << 22);
      wr(3'd0, 32'h0001_0007);
      line_len_check(48, "R8 locked write ignored");
      wait_frame_start();
      line_len_check(48, "R8 still ignored after a second wrap");
      wr(3'd4, 32'd0);
      wr(3'd0, 32'h0001_0007);
      line_len_check(64, "R8 unlocked write applies");
   endtask

   task automatic t_depth();
      for (int c = 0; c < 8; c++) begin
         int eb;
         case (c)
            1: eb = 1;   2: eb = 8;   3: eb = 15;
            4: eb = 16;  5: eb = 24;  6: eb = 32;
            default: eb = 0;
         endcase
         wr(3'd4, 32'(c) << 8);
         chk(int'(bpp) == eb, "R10 bpp decode", int'(bpp), eb);
         chk(int'(depth_code) == c, "R10 depth code", int'(depth_code), c);
      end
   endtask

   task automatic t_pitch();
      wr(3'd5, 32'd100 << 22);
      chk(pitch_px == 800, "R11 pitch 100 cells", int'(pitch_px), 800);
      wr(3'd5, 32'd1023 << 22);
      chk(pitch_px == 8184, "R11 pitch max", int'(pitch_px), 8184);
      wr(3'd5, 32'h003F_FFFF);
      chk(pitch_px == 0, "R11 low bits ignored", int'(pitch_px), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_default_frame();
      t_vga_neg();
      t_vga_pos();
      t_frame_boundary();
      t_lock();
      t_depth();
      t_pitch();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nchecks++;
         nerrs++;
         $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
         $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
         $finish;
      end
   end

endmodule